// File: doc/BRIEF.md
# Logical-OR Instruction Execution Unit

This block executes the logical-OR instruction group of a classic 8-bit accumulator microcontroller. It pulls an opcode byte and then its operand bytes from a byte-wide fetch stream. It decodes the form, takes exactly as many operand bytes as that form needs and spends the form's fixed number of machine cycles on it. At the end it commits the result and pulses `done` for one clock. The unit holds all the state the group touches: the accumulator, the carry bit, a direct-addressed RAM and the latch of one output port. The first eight RAM bytes also serve as the eight working registers. The port also has a separate pin-input bus.

The fetch stream is valid/ready. A byte moves only on a rising clock edge where `fetch_valid` and `fetch_ready` are both high. The source may raise or drop `fetch_valid` in any cycle. The unit raises `fetch_ready` while it is idle and while operand bytes are still owed. It holds `fetch_ready` low from the last operand byte until the cycle in which `done` is high. Operand bytes that arrive late stretch the instruction. They never shorten it. One machine cycle is `MC_CLKS` clocks. `RAM_DEPTH` must be 64 or 128.

Top module: `orx_or_unit`

## Requirements
- R1: During and right after reset, `acc`, `carry`, `port_latch` and every RAM byte are 0, `done` and `illegal` are 0, and `fetch_ready` is 1.
- R2: Opcodes 0x48..0x4F OR RAM byte `opcode[2:0]` (a working register) into `acc` (for example 0xC3 OR 0x55 gives 0xD7). Bits of `acc` are never cleared except by reset.
- R3: Opcode 0x44 ORs its operand byte into `acc`. Opcode 0x45 ORs the byte at the direct address in its operand into `acc`. When that address is `PORT_ADDR` (0x80), the value comes from `port_pins`.
- R4: Opcodes 0x46/0x47 use RAM byte 0 or 1 (`opcode[0]`) as a pointer and OR the RAM byte it points to into `acc`. A pointer of `RAM_DEPTH` or above yields 0.
- R5: Opcode 0x42 ORs `acc` into the direct-addressed byte. Opcode 0x43 ORs its second operand byte into the byte addressed by its first operand byte. When the target is the port, the old value is the port latch, not `port_pins`. The latch changes only through these two forms.
- R6: Opcode 0x72 sets `carry` to `carry | b` and opcode 0xA0 sets it to `carry | ~b`. The bit b is found from its bit address as follows. Address a < 0x80 is bit a[2:0] of RAM byte 0x20 + a[6:3]. Addresses 0x80..0x87 are bits 0..7 of the port latch. The addressed bit is not modified, and `carry` never falls outside reset.
- R7: The byte forms never change `carry`. The bit forms change nothing but `carry`.
- R8: A form takes exactly the following numbers of bytes, opcode included: 0x48..0x4F, 0x46 and 0x47 take 1; 0x44, 0x45, 0x42, 0x72 and 0xA0 take 2; 0x43 takes 3. After the last operand byte, `fetch_ready` stays low until `done`.
- R9: The forms 0x72, 0xA0 and 0x43 last 2 machine cycles and every other form lasts 1. With operands supplied without gaps, `done` is high for one clock, N·MC_CLKS−1 clocks after the opcode edge, and the result is visible in that clock. A late final operand moves `done` to the clock after that operand's edge.
- R10: Any other opcode pulses `illegal` for the one clock after its edge. It consumes no operand bytes, so the next byte is read as an opcode, and it leaves all state unchanged.
- R11: Direct addresses that are neither RAM nor `PORT_ADDR` read as 0 and discard writes. Bit addresses that map to nothing read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Fetch byte present |
| fetch_data | input | 8 | Opcode or operand byte |
| fetch_ready | output | 1 | Unit accepts a byte this cycle |
| port_pins | input | 8 | Pin levels of the output port |
| port_latch | output | 8 | Output port latch |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry bit |
| done | output | 1 | One-clock pulse at instruction commit |
| illegal | output | 1 | One-clock pulse for an opcode outside the group |

## Verification
The assertions check several rules on every clock:
- `acc` never loses a set bit and `carry` never falls.
- `carry` moves only on a bit-form commit, `acc` only on an accumulator-destination commit, and the port latch only on a direct-destination commit.
- `done` is a single-clock pulse that never coincides with `illegal`.
- An illegal opcode never starts an instruction.

Other behaviour can be shown only by the bench's scenarios, each compared with a reference model:
- the exact commit clock under gap-free and stalled operand streams;
- the pin-versus-latch choice for the port;
- indirect pointers that run past the RAM;
- the bit-address mapping;
- the worked 0xC3/0x55 case.

// File: rtl/orx_pkg.sv
package orx_pkg;

  typedef enum logic [3:0] {
    F_NONE   = 4'd0,
    F_A_REG  = 4'd1,
    F_A_DIR  = 4'd2,
    F_A_IND  = 4'd3,
    F_A_IMM  = 4'd4,
    F_D_ACC  = 4'd5,
    F_D_IMM  = 4'd6,
    F_C_BIT  = 4'd7,
    F_C_NBIT = 4'd8
  } form_e;

  typedef struct packed {
    form_e      form;
    logic [1:0] nbytes;
    logic [1:0] nmc;
    logic       legal;
  } dec_t;

endpackage

// File: rtl/orx_decode.sv
module orx_decode
  import orx_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec = '{form: F_NONE, nbytes: 2'd1, nmc: 2'd1, legal: 1'b0};
    casez (opcode)
      8'b0100_1???: dec = '{form: F_A_REG,  nbytes: 2'd1, nmc: 2'd1, legal: 1'b1};
      8'b0100_011?: dec = '{form: F_A_IND,  nbytes: 2'd1, nmc: 2'd1, legal: 1'b1};
      8'h45:        dec = '{form: F_A_DIR,  nbytes: 2'd2, nmc: 2'd1, legal: 1'b1};
      8'h44:        dec = '{form: F_A_IMM,  nbytes: 2'd2, nmc: 2'd1, legal: 1'b1};
      8'h42:        dec = '{form: F_D_ACC,  nbytes: 2'd2, nmc: 2'd1, legal: 1'b1};
      8'h43:        dec = '{form: F_D_IMM,  nbytes: 2'd3, nmc: 2'd2, legal: 1'b1};
      8'h72:        dec = '{form: F_C_BIT,  nbytes: 2'd2, nmc: 2'd2, legal: 1'b1};
      8'hA0:        dec = '{form: F_C_NBIT, nbytes: 2'd2, nmc: 2'd2, legal: 1'b1};
      default:      dec = '{form: F_NONE,   nbytes: 2'd1, nmc: 2'd1, legal: 1'b0};
    endcase
  end

endmodule

// File: rtl/orx_seq.sv
module orx_seq
  import orx_pkg::*;
#(
  parameter int MC_CLKS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_valid,
  input  logic [7:0] fetch_data,
  output logic       fetch_ready,
  input  dec_t       dec,
  output form_e      form,
  output logic [2:0] op_low,
  output logic [7:0] opnd1,
  output logic [7:0] opnd2,
  output logic       commit,
  output logic       done,
  output logic       illegal
);

  localparam int CW = $clog2(2 * MC_CLKS) + 1;
  localparam logic [CW-1:0] LAST1 = CW'(MC_CLKS - 1);
  localparam logic [CW-1:0] LAST2 = CW'(2 * MC_CLKS - 1);

  logic          busy_q;
  form_e         form_q;
  logic [2:0]    opl_q;
  logic [1:0]    left_q;
  logic [CW-1:0] last_q;
  logic [CW-1:0] cnt_q;
  logic          got1_q;
  logic [7:0]    op1_q, op2_q;
  logic          done_q, illegal_q;
  logic          take;

  assign fetch_ready = !busy_q || (left_q != 2'd0);
  assign take        = fetch_valid && fetch_ready;
  assign commit      = busy_q && (left_q == 2'd0) && (cnt_q >= last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      form_q    <= F_NONE;
      opl_q     <= '0;
      left_q    <= '0;
      last_q    <= LAST1;
      cnt_q     <= '0;
      got1_q    <= 1'b0;
      op1_q     <= '0;
      op2_q     <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= commit;
      illegal_q <= take && !busy_q && !dec.legal;
      if (!busy_q) begin
        if (take && dec.legal) begin
          busy_q <= 1'b1;
          form_q <= dec.form;
          opl_q  <= fetch_data[2:0];
          left_q <= dec.nbytes - 2'd1;
          last_q <= (dec.nmc == 2'd2) ? LAST2 : LAST1;
          cnt_q  <= CW'(1);
          got1_q <= 1'b0;
        end
      end else begin
        if (cnt_q != '1) cnt_q <= cnt_q + CW'(1);
        if (take) begin
          if (!got1_q) op1_q <= fetch_data;
          else         op2_q <= fetch_data;
          got1_q <= 1'b1;
          left_q <= left_q - 2'd1;
        end
        if (commit) busy_q <= 1'b0;
      end
    end
  end

  assign form    = form_q;
  assign op_low  = opl_q;
  assign opnd1   = op1_q;
  assign opnd2   = op2_q;
  assign done    = done_q;
  assign illegal = illegal_q;

  // R9: the commit pulse lasts exactly one clock
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: an illegal opcode never opens an instruction
  assert_illegal_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> !busy_q);

  // R10: illegal and done never share a clock
  assert_done_illegal_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && illegal_q));

endmodule

// File: rtl/orx_datapath.sv
module orx_datapath
  import orx_pkg::*;
#(
  parameter int         RAM_DEPTH = 128,
  parameter logic [7:0] PORT_ADDR = 8'h80,
  parameter logic [7:0] BIT_BASE  = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  form_e      form,
  input  logic [2:0] op_low,
  input  logic [7:0] opnd1,
  input  logic [7:0] opnd2,
  input  logic [7:0] port_pins,
  output logic [7:0] acc,
  output logic       carry,
  output logic [7:0] port_latch
);

  localparam int AW = $clog2(RAM_DEPTH);

  logic [7:0] ram_q [RAM_DEPTH];
  logic [7:0] acc_q, port_q;
  logic       carry_q;

  logic [7:0] reg_val, ptr, ind_val, src_dir, old_dir, bit_byte, wr_val;
  logic       dir_is_ram, dir_is_port, bit_val;
  logic [7:0] acc_nx;
  logic       carry_nx, ram_we, port_we;

  assign dir_is_ram  = (opnd1[7:AW] == '0);
  assign dir_is_port = (opnd1 == PORT_ADDR);
  assign reg_val     = ram_q[AW'(op_low)];
  assign ptr         = ram_q[AW'(op_low[0])];
  assign ind_val     = (ptr[7:AW] == '0) ? ram_q[ptr[AW-1:0]] : 8'h00;

  // plain read takes the pins; read-modify-write takes the latch
  assign src_dir = dir_is_ram  ? ram_q[opnd1[AW-1:0]] :
                   dir_is_port ? port_pins : 8'h00;
  assign old_dir = dir_is_ram  ? ram_q[opnd1[AW-1:0]] :
                   dir_is_port ? port_q : 8'h00;

  assign bit_byte = ram_q[AW'(BIT_BASE) + AW'(opnd1[6:3])];
  assign bit_val  = !opnd1[7]                       ? bit_byte[opnd1[2:0]] :
                    (opnd1[7:3] == PORT_ADDR[7:3])  ? port_q[opnd1[2:0]]   : 1'b0;

  always_comb begin
    acc_nx   = acc_q;
    carry_nx = carry_q;
    wr_val   = old_dir;
    ram_we   = 1'b0;
    port_we  = 1'b0;
    unique case (form)
      F_A_REG:  acc_nx = acc_q | reg_val;
      F_A_DIR:  acc_nx = acc_q | src_dir;
      F_A_IND:  acc_nx = acc_q | ind_val;
      F_A_IMM:  acc_nx = acc_q | opnd1;
      F_D_ACC: begin
        wr_val  = old_dir | acc_q;
        ram_we  = dir_is_ram;
        port_we = dir_is_port;
      end
      F_D_IMM: begin
        wr_val  = old_dir | opnd2;
        ram_we  = dir_is_ram;
        port_we = dir_is_port;
      end
      F_C_BIT:  carry_nx = carry_q | bit_val;
      F_C_NBIT: carry_nx = carry_q | !bit_val;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
      port_q  <= '0;
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
    end else if (commit) begin
      acc_q   <= acc_nx;
      carry_q <= carry_nx;
      if (port_we) port_q <= wr_val;
      if (ram_we)  ram_q[opnd1[AW-1:0]] <= wr_val;
    end
  end

  assign acc        = acc_q;
  assign carry      = carry_q;
  assign port_latch = port_q;

  logic is_bit_form, is_acc_form, is_dir_form;
  assign is_bit_form = (form == F_C_BIT) || (form == F_C_NBIT);
  assign is_acc_form = (form == F_A_REG) || (form == F_A_DIR) ||
                       (form == F_A_IND) || (form == F_A_IMM);
  assign is_dir_form = (form == F_D_ACC) || (form == F_D_IMM);

  // R2: OR never clears an accumulator bit
  assert_acc_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_q & $past(acc_q)) == $past(acc_q)));

  // R6: carry is only ever set by the bit forms
  assert_carry_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(carry_q));

  // R7: carry moves only on a bit-form commit
  assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && is_bit_form) |=> $stable(carry_q));

  // R7: accumulator moves only on an accumulator-destination commit
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && is_acc_form) |=> $stable(acc_q));

  // R5: port latch moves only on a direct-destination commit
  assert_port_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && is_dir_form) |=> $stable(port_q));

endmodule

// File: rtl/orx_or_unit.sv
module orx_or_unit
  import orx_pkg::*;
#(
  parameter int         MC_CLKS   = 12,
  parameter int         RAM_DEPTH = 128,
  parameter logic [7:0] PORT_ADDR = 8'h80,
  parameter logic [7:0] BIT_BASE  = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_valid,
  input  logic [7:0] fetch_data,
  output logic       fetch_ready,
  input  logic [7:0] port_pins,
  output logic [7:0] port_latch,
  output logic [7:0] acc,
  output logic       carry,
  output logic       done,
  output logic       illegal
);

  dec_t       dec;
  form_e      form;
  logic [2:0] op_low;
  logic [7:0] opnd1, opnd2;
  logic       commit;

  orx_decode u_dec (
    .opcode (fetch_data),
    .dec    (dec)
  );

  orx_seq #(.MC_CLKS(MC_CLKS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .fetch_ready (fetch_ready),
    .dec         (dec),
    .form        (form),
    .op_low      (op_low),
    .opnd1       (opnd1),
    .opnd2       (opnd2),
    .commit      (commit),
    .done        (done),
    .illegal     (illegal)
  );

  orx_datapath #(
    .RAM_DEPTH (RAM_DEPTH),
    .PORT_ADDR (PORT_ADDR),
    .BIT_BASE  (BIT_BASE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .form       (form),
    .op_low     (op_low),
    .opnd1      (opnd1),
    .opnd2      (opnd2),
    .port_pins  (port_pins),
    .acc        (acc),
    .carry      (carry),
    .port_latch (port_latch)
  );

endmodule

// File: tb/sim_orx_or_unit.sv
module sim_orx_or_unit;

  localparam int MC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       f_valid = 1'b0;
  logic [7:0] f_data = 8'h00;
  logic       f_ready;
  logic [7:0] pins = 8'h00;
  logic [7:0] port_latch, acc;
  logic       carry, done, illegal;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_ram [128];
  logic [7:0] m_acc, m_port;
  logic       m_c;

  orx_or_unit u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(f_valid), .fetch_data(f_data),
    .fetch_ready(f_ready), .port_pins(pins), .port_latch(port_latch),
    .acc(acc), .carry(carry), .done(done), .illegal(illegal)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL R9 watchdog: cycles %0d expected below %0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // returns bytes*10 + machine cycles, 0 for an opcode outside the group
  function automatic int m_len(input logic [7:0] op);
    if (op[7:3] == 5'b01001)      return 11;
    if (op == 8'h46 || op == 8'h47) return 11;
    if (op == 8'h44 || op == 8'h45 || op == 8'h42) return 21;
    if (op == 8'h43) return 32;
    if (op == 8'h72 || op == 8'hA0) return 22;
    return 0;
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    if (op[7:3] == 5'b01001)      return "R2";
    if (op == 8'h44 || op == 8'h45) return "R3";
    if (op == 8'h46 || op == 8'h47) return "R4";
    if (op == 8'h42 || op == 8'h43) return "R5";
    return "R6";
  endfunction

  function automatic logic [7:0] m_src(input logic [7:0] a);
    if (a < 8'h80) return m_ram[a[6:0]];
    if (a == 8'h80) return pins;
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_old(input logic [7:0] a);
    if (a < 8'h80) return m_ram[a[6:0]];
    if (a == 8'h80) return m_port;
    return 8'h00;
  endfunction

  function automatic logic m_bit(input logic [7:0] a);
    logic [7:0] byt;
    if (a < 8'h80) begin
      byt = m_ram[7'h20 + {3'b000, a[6:3]}];
      return byt[a[2:0]];
    end
    if (a <= 8'h87) return m_port[a[2:0]];
    return 1'b0;
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [7:0] v);
    if (a < 8'h80) m_ram[a[6:0]] = v;
    else if (a == 8'h80) m_port = v;
  endtask

  task automatic m_apply(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] p;
    if (op[7:3] == 5'b01001) m_acc = m_acc | m_ram[{4'b0000, op[2:0]}];
    else if (op == 8'h45) m_acc = m_acc | m_src(b1);
    else if (op == 8'h44) m_acc = m_acc | b1;
    else if (op == 8'h46 || op == 8'h47) begin
      p = m_ram[{6'b000000, op[0]}];
      m_acc = m_acc | ((p < 8'h80) ? m_ram[p[6:0]] : 8'h00);
    end
    else if (op == 8'h42) m_write(b1, m_old(b1) | m_acc);
    else if (op == 8'h43) m_write(b1, m_old(b1) | b2);
    else if (op == 8'h72) m_c = m_c | m_bit(b1);
    else if (op == 8'hA0) m_c = m_c | !m_bit(b1);
  endtask

  task automatic cmp_state(input string req);
    chk(req, "acc", int'(acc), int'(m_acc));
    chk(req, "carry", int'(carry), int'(m_c));
    chk(req, "port_latch", int'(port_latch), int'(m_port));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; f_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) m_ram[i] = 8'h00;
    m_acc = 8'h00; m_port = 8'h00; m_c = 1'b0;
    chk("R1", "acc after reset", int'(acc), 0);
    chk("R1", "carry after reset", int'(carry), 0);
    chk("R1", "port after reset", int'(port_latch), 0);
    chk("R1", "done/illegal after reset", int'({done, illegal}), 0);
    chk("R1", "ready after reset", int'(f_ready), 1);
  endtask

  task automatic push(input logic [7:0] b, output int t);
    @(negedge clk);
    f_valid = 1'b1; f_data = b;
    while (!f_ready) @(negedge clk);
    t = cyc;
    @(posedge clk);
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                     input int gap);
    int  len, nb, nm, t0, tl, exp_t;
    bit  rdy_bad;
    len = m_len(op);
    nb = len / 10; nm = len % 10;
    push(op, t0);
    tl = t0;
    if (len == 0) begin
      @(negedge clk);
      f_valid = 1'b0;
      chk("R10", "illegal pulse", int'(illegal), 1);
      chk("R10", "no done on illegal", int'(done), 0);
      cmp_state("R10");
      @(negedge clk);
      chk("R10", "illegal lasts one clock", int'(illegal), 0);
      return;
    end
    if (nb > 1) begin
      repeat (gap) begin @(negedge clk); f_valid = 1'b0; end
      push(b1, tl);
    end
    if (nb > 2) begin
      repeat (gap) begin @(negedge clk); f_valid = 1'b0; end
      push(b2, tl);
    end
    m_apply(op, b1, b2);
    rdy_bad = 1'b0;
    forever begin
      @(negedge clk);
      if (done) begin f_valid = 1'b0; break; end
      f_valid = 1'b1; f_data = 8'hEE;
      if (f_ready) rdy_bad = 1'b1;
    end
    exp_t = t0 + nm * MC;
    if (tl + 2 > exp_t) exp_t = tl + 2;
    chk("R9", "done clock", cyc, exp_t);
    chk("R8", "ready low until done", int'(rdy_bad), 0);
    cmp_state(tag_of(op));
  endtask

  function automatic logic [7:0] rnd_dir();
    case ($urandom % 4)
      0: return 8'($urandom % 16);
      1: return 8'(32'h20 + $urandom % 16);
      2: return 8'h80;
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [7:0] rnd_bit();
    case ($urandom % 3)
      0: return 8'($urandom % 128);
      1: return 8'(32'h80 + $urandom % 8);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    logic [7:0] op, b1, b2;
    int gap;
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R2 worked case: R0=0x55, A=0xC3, OR register 0 gives 0xD7
    run(8'h43, 8'h00, 8'h55, 0);
    run(8'h44, 8'hC3, 8'h00, 0);
    run(8'h48, 8'h00, 8'h00, 0);
    chk("R2", "worked case 0xD7", int'(acc), 8'hD7);

    // R5 port uses latch, R3 plain read uses pins
    do_reset();
    pins = 8'hFF;
    run(8'h43, 8'h80, 8'h32, 0);
    chk("R5", "port from latch", int'(port_latch), 8'h32);
    pins = 8'h0F;
    run(8'h45, 8'h80, 8'h00, 0);
    chk("R3", "acc from pins", int'(acc), 8'h0F);

    // R4 indirect, in range and past the RAM
    do_reset();
    run(8'h43, 8'h01, 8'h30, 0);
    run(8'h43, 8'h30, 8'h9C, 0);
    run(8'h47, 8'h00, 8'h00, 0);
    chk("R4", "indirect via R1", int'(acc), 8'h9C);
    run(8'h43, 8'h00, 8'h90, 0);
    run(8'h43, 8'h10, 8'h03, 0);
    run(8'h46, 8'h00, 8'h00, 0);
    chk("R4", "pointer past RAM reads 0", int'(acc), 8'h9C);

    // R6 bit forms and mapping
    do_reset();
    run(8'h43, 8'h21, 8'h04, 0);
    run(8'h72, 8'h0B, 8'h00, 0);
    chk("R6", "clear bit leaves carry", int'(carry), 0);
    run(8'h72, 8'h0A, 8'h00, 0);
    chk("R6", "set bit sets carry", int'(carry), 1);
    run(8'h45, 8'h21, 8'h00, 0);
    chk("R6", "source bit untouched", int'(acc), 8'h04);
    do_reset();
    run(8'h43, 8'h21, 8'h04, 0);
    run(8'hA0, 8'h0A, 8'h00, 0);
    chk("R6", "complement of 1 keeps carry", int'(carry), 0);
    run(8'h43, 8'h80, 8'h02, 0);
    run(8'hA0, 8'h81, 8'h00, 0);
    chk("R6", "port bit 1 complemented", int'(carry), 0);
    run(8'h72, 8'h81, 8'h00, 0);
    chk("R6", "port bit via latch", int'(carry), 1);

    // R11 unmapped addresses
    do_reset();
    run(8'h43, 8'h95, 8'hFF, 0);
    run(8'h45, 8'h95, 8'h00, 0);
    chk("R11", "unmapped direct reads 0", int'(acc), 0);
    run(8'hA0, 8'h90, 8'h00, 0);
    chk("R11", "unmapped bit reads 0", int'(carry), 1);

    // R10 illegal then immediate opcode; R9 stalled operands
    do_reset();
    run(8'h00, 8'h00, 8'h00, 0);
    run(8'h44, 8'h21, 8'h00, 0);
    chk("R10", "next byte is opcode", int'(acc), 8'h21);
    run(8'hFF, 8'h00, 8'h00, 0);
    run(8'h44, 8'h40, 8'h00, 15);
    run(8'h43, 8'h05, 8'h66, 20);
    run(8'h72, 8'h28, 8'h00, 3);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      if (i % 10 == 0) do_reset();
      pins = 8'($urandom);
      gap = ($urandom % 6 == 0) ? int'($urandom % 16) : 0;
      b2 = 8'($urandom);
      case ($urandom % 10)
        0, 9: begin op = 8'h48 | 8'($urandom % 8); b1 = 8'h00; end
        1: begin op = 8'h45; b1 = rnd_dir(); end
        2: begin op = 8'h46 | 8'($urandom % 2); b1 = 8'h00; end
        3: begin op = 8'h44; b1 = 8'($urandom); end
        4: begin op = 8'h42; b1 = rnd_dir(); end
        5: begin op = 8'h43; b1 = rnd_dir(); b2 = 8'($urandom) & 8'($urandom); end
        6: begin op = 8'h72; b1 = rnd_bit(); end
        7: begin op = 8'hA0; b1 = rnd_bit(); end
        default: begin
          do op = 8'($urandom); while (m_len(op) != 0);
          b1 = 8'h00;
        end
      endcase
      run(op, b1, b2, gap);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule